// File: doc/BRIEF.md
# JPEG Entropy Bit Packer

The packer sits between an entropy coder and a byte-wide output stream in a baseline JPEG encoder. Each accepted input item is either a variable-length code word, an MCU-end tick, a flush request or an end-of-image request. Code words are shifted MSB-first into a 64-bit accumulator, and whole bytes leave on an 8-bit streaming master that has valid and last but no ready, so the sink takes every valid byte. Every data byte equal to 0xFF is followed by an inserted 0x00 byte.

Markers are written by the packer itself. A non-zero MCU count on `restart_mcus` arms a restart marker after that many MCU-end ticks. The marker is placed just before the next code word, so it never separates the last MCU from the end of the image. Before any marker, and on a flush, the pending bits are padded with 1 bits to a byte boundary and drained. The end-of-image request finishes the frame with a last-flagged marker, and the number of bytes in the frame is latched on that final byte.

Top module: `jpeg_bit_packer`

## Requirements
- R1: After a synchronous active-high reset, `m_tvalid` and `m_tlast` are low, `frame_bytes` is 0 and `in_ready` is high.
- R2: An input with `in_kind`=0 carries a code word in the low `in_len` bits (1 to 27) of `in_bits`. Code words are packed MSB-first in arrival order, and bytes leave in that order, one byte per cycle at most.
- R3: Every data byte equal to 0xFF is followed, in the very next cycle, by a 0x00 byte.
- R4: A flush request (`in_kind`=2) pads the pending bits with 1 bits up to the next byte boundary and emits every pending byte. Padding that forms 0xFF is stuffed like any other data byte.
- R5: `in_ready` is low for a code word while the accumulator holds more than 37 bits. Under that backpressure no code word is lost or reordered.
- R6: With `restart_mcus`=N and N not zero, every N MCU-end ticks (`in_kind`=1) arm a restart. The next code word is held back while the pending bits are padded, drained and followed by a restart marker. With N=0, no restart marker appears.
- R7: Restart markers are 0xFF 0xD0 through 0xFF 0xD7 in sequence, wrap back to 0xD0 after 0xD7, and start from 0xD0 again in each new frame.
- R8: The two bytes of any marker are sent unstuffed: a marker 0xFF is followed directly by its code byte.
- R9: An end-of-image request (`in_kind`=3) pads and drains, then sends 0xFF 0xD9 with `m_tlast` high on 0xD9 only. A restart armed but not yet placed is discarded.
- R10: On the cycle `m_tlast` is high, `frame_bytes` becomes the number of bytes sent in the frame, counting stuffed bytes and markers. It holds that value until the next frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Input item accepted when high with in_valid |
| in_kind | input | 2 | 0 code word, 1 MCU end, 2 flush, 3 end of image |
| in_bits | input | 27 | Code word value, right-aligned |
| in_len | input | 5 | Code word length in bits |
| restart_mcus | input | 16 | MCUs per restart interval, 0 disables |
| m_tdata | output | 8 | Output byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tlast | output | 1 | Last byte of the frame |
| frame_bytes | output | 24 | Byte count of the last completed frame |

## Verification
On every cycle, the assertions check three things. A data 0xFF is followed at once by 0x00. A marker prefix is followed at once by a marker code byte. The last flag appears only on 0xD9, and the frame count changes only with it. Only the bench scenarios can show the rest. That covers bit order across byte boundaries, the 1-bit padding, the timing and wrap of restart markers, the discarding of a restart armed just before the end of the image, and the absence of loss under backpressure. The bench does this by comparing each whole frame against a bit-level model.

// File: rtl/jbp_pkg.sv
package jbp_pkg;

    localparam int ACC_BITS  = 64;
    localparam int CODE_BITS = 27;
    localparam int LEN_BITS  = 5;

    localparam logic [7:0] MARK_PREFIX = 8'hFF;
    localparam logic [7:0] MARK_RST0   = 8'hD0;
    localparam logic [7:0] MARK_END    = 8'hD9;

    typedef enum logic [1:0] {
        K_CODE  = 2'd0,
        K_MCU   = 2'd1,
        K_FLUSH = 2'd2,
        K_EOI   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_DRAIN,
        ST_MK_HI,
        ST_MK_LO
    } state_e;

    typedef enum logic [1:0] {
        AF_FLUSH,
        AF_RST,
        AF_EOI
    } after_e;

    typedef struct packed {
        logic       valid;
        logic       last;
        logic       mark;
        logic [7:0] data;
    } beat_t;

    function automatic logic [7:0] marker_code(after_e af, logic [2:0] idx);
        return (af == AF_EOI) ? MARK_END : (MARK_RST0 | {5'b0, idx});
    endfunction

endpackage

// File: rtl/jbp_restart_ctl.sv
module jbp_restart_ctl #(
    parameter int INTV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INTV_W-1:0] interval,
    input  logic              mcu_tick,
    input  logic              mark_done,
    input  logic              frame_end,
    output logic              pending,
    output logic [2:0]        idx
);
    logic [INTV_W-1:0] mcu_q;

    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            mcu_q   <= '0;
            pending <= 1'b0;
            idx     <= 3'd0;
        end else begin
            if (mark_done) begin
                pending <= 1'b0;
                idx     <= idx + 3'd1;
            end
            if (mcu_tick && interval != '0) begin
                if (mcu_q + INTV_W'(1) >= interval) begin
                    mcu_q   <= '0;
                    pending <= 1'b1;
                end else begin
                    mcu_q <= mcu_q + INTV_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/jbp_frame_count.sv
module jbp_frame_count #(
    parameter int BCNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat,
    input  logic              last,
    output logic [BCNT_W-1:0] frame_bytes
);
    logic [BCNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q       <= '0;
            frame_bytes <= '0;
        end else if (beat) begin
            if (last) begin
                frame_bytes <= run_q + BCNT_W'(1);
                run_q       <= '0;
            end else begin
                run_q <= run_q + BCNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/jpeg_bit_packer.sv
module jpeg_bit_packer
    import jbp_pkg::*;
#(
    parameter int ACC_W  = ACC_BITS,
    parameter int CODE_W = CODE_BITS,
    parameter int LEN_W  = LEN_BITS,
    parameter int INTV_W = 16,
    parameter int BCNT_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_kind,
    input  logic [CODE_W-1:0] in_bits,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [INTV_W-1:0] restart_mcus,
    output logic [7:0]        m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    output logic [BCNT_W-1:0] frame_bytes
);
    localparam int CNT_W = $clog2(ACC_W + 1);
    localparam int ROOM  = ACC_W - CODE_W;
    localparam logic [ACC_W-1:0] ONES = '1;

    kind_e              kind;
    state_e             st_q, st_d;
    after_e             af_q, af_d, pad_af;
    logic [ACC_W-1:0]   acc_q, acc_d, acc_a, pad, code_w;
    logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_a, cnt_r, sh;
    logic               stuff_q, stuff_d, do_pad;
    beat_t              ob_q, ob_d;
    logic               rst_pend, mcu_tick, mark_done, frame_end;
    logic [2:0]         rst_idx;

    assign kind   = kind_e'(in_kind);
    assign code_w = ACC_W'(in_bits & ~({CODE_W{1'b1}} << in_len));

    assign in_ready = (st_q == ST_RUN) &&
                      (kind != K_CODE || (cnt_q <= CNT_W'(ROOM) && !rst_pend));

    always_comb begin
        st_d      = st_q;
        af_d      = af_q;
        stuff_d   = stuff_q;
        ob_d      = '0;
        mcu_tick  = 1'b0;
        mark_done = 1'b0;
        frame_end = 1'b0;
        do_pad    = 1'b0;
        pad_af    = AF_FLUSH;
        acc_a     = acc_q;
        cnt_a     = cnt_q;

        // byte emission: a pending stuff byte wins over new data
        if (st_q == ST_RUN || st_q == ST_DRAIN) begin
            if (stuff_q) begin
                ob_d.valid = 1'b1;
                ob_d.data  = 8'h00;
                stuff_d    = 1'b0;
            end else if (cnt_q >= CNT_W'(8)) begin
                ob_d.valid = 1'b1;
                ob_d.data  = acc_q[ACC_W-1 -: 8];
                acc_a      = acc_q << 8;
                cnt_a      = cnt_q - CNT_W'(8);
                stuff_d    = (acc_q[ACC_W-1 -: 8] == 8'hFF);
            end
        end

        acc_d = acc_a;
        cnt_d = cnt_a;
        cnt_r = (cnt_a + CNT_W'(7)) & ~CNT_W'(7);
        pad   = ~(ONES >> cnt_r) & (ONES >> cnt_a);
        sh    = CNT_W'(ACC_W) - cnt_a - CNT_W'(in_len);

        case (st_q)
            ST_RUN: begin
                if (in_valid && kind == K_CODE && rst_pend) begin
                    do_pad = 1'b1;
                    pad_af = AF_RST;
                end else if (in_valid && in_ready) begin
                    case (kind)
                        K_CODE: begin
                            acc_d = acc_a | (code_w << sh);
                            cnt_d = cnt_a + CNT_W'(in_len);
                        end
                        K_MCU:   mcu_tick = 1'b1;
                        K_FLUSH: begin
                            do_pad = 1'b1;
                            pad_af = AF_FLUSH;
                        end
                        default: begin
                            do_pad = 1'b1;
                            pad_af = AF_EOI;
                        end
                    endcase
                end
            end
            ST_DRAIN: begin
                if (!stuff_q && cnt_q == '0)
                    st_d = (af_q == AF_FLUSH) ? ST_RUN : ST_MK_HI;
            end
            ST_MK_HI: begin
                ob_d = '{valid: 1'b1, last: 1'b0, mark: 1'b1, data: MARK_PREFIX};
                st_d = ST_MK_LO;
            end
            default: begin
                ob_d = '{valid: 1'b1, last: (af_q == AF_EOI), mark: 1'b1,
                         data: marker_code(af_q, rst_idx)};
                st_d = ST_RUN;
                if (af_q == AF_EOI) frame_end = 1'b1;
                else                mark_done = 1'b1;
            end
        endcase

        if (do_pad) begin
            acc_d = acc_a | pad;
            cnt_d = cnt_r;
            st_d  = ST_DRAIN;
            af_d  = pad_af;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_RUN;
            af_q    <= AF_FLUSH;
            acc_q   <= '0;
            cnt_q   <= '0;
            stuff_q <= 1'b0;
            ob_q    <= '0;
        end else begin
            st_q    <= st_d;
            af_q    <= af_d;
            acc_q   <= acc_d;
            cnt_q   <= cnt_d;
            stuff_q <= stuff_d;
            ob_q    <= ob_d;
        end
    end

    assign m_tdata  = ob_q.data;
    assign m_tvalid = ob_q.valid;
    assign m_tlast  = ob_q.last;

    jbp_restart_ctl #(.INTV_W(INTV_W)) u_rst (
        .clk       (clk),
        .rst       (rst),
        .interval  (restart_mcus),
        .mcu_tick  (mcu_tick),
        .mark_done (mark_done),
        .frame_end (frame_end),
        .pending   (rst_pend),
        .idx       (rst_idx)
    );

    jbp_frame_count #(.BCNT_W(BCNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .beat        (ob_d.valid),
        .last        (ob_d.last),
        .frame_bytes (frame_bytes)
    );
endmodule

// File: rtl/jbp_checker.sv
module jbp_checker #(
    parameter int BCNT_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              vld,
    input logic [7:0]        dat,
    input logic              lst,
    input logic              mrk,
    input logic [BCNT_W-1:0] fbytes
);
    // R3: data 0xFF is followed at once by the stuffed zero
    p_stuff_next_r3: assert property (@(posedge clk) disable iff (rst)
        (vld && !mrk && dat == 8'hFF) |=> (vld && !mrk && dat == 8'h00));

    // R8: a marker prefix is followed at once by its code byte
    p_marker_pair_r8: assert property (@(posedge clk) disable iff (rst)
        (vld && mrk && dat == 8'hFF) |=> (vld && mrk && dat[7:4] == 4'hD));

    // R9: last flag only on the end-of-image code byte
    p_last_on_eoi_r9: assert property (@(posedge clk) disable iff (rst)
        lst |-> (vld && mrk && dat == 8'hD9));

    // R10: the frame count changes only together with the last byte
    p_count_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !lst |-> $stable(fbytes));
endmodule

bind jpeg_bit_packer jbp_checker #(.BCNT_W(BCNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .vld    (m_tvalid),
    .dat    (m_tdata),
    .lst    (m_tlast),
    .mrk    (ob_q.mark),
    .fbytes (frame_bytes)
);

// File: tb/jpeg_bit_packer_tb.sv
`timescale 1ns/1ps
module jpeg_bit_packer_tb;
    import jbp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = 2'd0;
    logic [26:0] in_bits = '0;
    logic [4:0]  in_len = '0;
    logic [15:0] restart_mcus = '0;
    logic [7:0]  m_tdata;
    logic        m_tvalid;
    logic        m_tlast;
    logic [23:0] frame_bytes;

    always #2.5 clk = ~clk;

    jpeg_bit_packer u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_bits(in_bits), .in_len(in_len),
        .restart_mcus(restart_mcus), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tlast(m_tlast), .frame_bytes(frame_bytes)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int stalls = 0;
    bit finished = 0;

    logic [7:0] got_d[$];
    bit         got_l[$];
    int         got_c[$];

    bit         mq[$];
    logic [7:0] eq[$];
    int         m_cnt = 0;
    int         m_idx = 0;
    bit         m_pend = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && m_tvalid) begin
            got_d.push_back(m_tdata);
            got_l.push_back(m_tlast);
            got_c.push_back(cyc);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    task automatic m_bits(input logic [26:0] b, input int l);
        for (int i = l - 1; i >= 0; i--) mq.push_back(b[i]);
    endtask

    task automatic m_align();
        while (mq.size() % 8 != 0) mq.push_back(1'b1);
        while (mq.size() >= 8) begin
            logic [7:0] v;
            for (int i = 0; i < 8; i++) v = {v[6:0], mq.pop_front()};
            eq.push_back(v);
            if (v == 8'hFF) eq.push_back(8'h00);
        end
    endtask

    // ---------------- drive ----------------
    task automatic put(input logic [1:0] k, input logic [26:0] b, input logic [4:0] l);
        bit ok;
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_bits = b; in_len = l;
        forever begin
            #0.5;
            ok = in_ready;
            if (!ok && k == 2'd0) stalls++;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
        #0.5 in_valid = 1'b0;
    endtask

    task automatic op_code(input logic [26:0] b, input int l);
        if (m_pend) begin
            m_align();
            eq.push_back(8'hFF);
            eq.push_back(8'hD0 + 8'(m_idx));
            m_idx = (m_idx + 1) % 8;
            m_pend = 0;
        end
        m_bits(b, l);
        put(2'd0, b, 5'(l));
    endtask

    task automatic op_mcu();
        if (restart_mcus != 0) begin
            m_cnt++;
            if (m_cnt >= int'(restart_mcus)) begin m_cnt = 0; m_pend = 1; end
        end
        put(2'd1, '0, '0);
    endtask

    task automatic op_flush();
        m_align();
        put(2'd2, '0, '0);
    endtask

    // end of image, then compare the whole frame
    task automatic op_eoi_check(input string req);
        int n;
        m_align();
        eq.push_back(8'hFF);
        eq.push_back(8'hD9);
        m_cnt = 0; m_idx = 0; m_pend = 0;
        put(2'd3, '0, '0);
        for (int w = 0; w < 400; w++) begin
            @(negedge clk);
            if (got_l.size() > 0 && got_l[got_l.size() - 1]) break;
        end
        repeat (3) @(negedge clk);
        n = got_d.size();
        chk(n == eq.size(), req, "frame length", n, eq.size());
        for (int i = 0; i < n && i < eq.size(); i++) begin
            chk(got_d[i] == eq[i], req, $sformatf("byte %0d", i), got_d[i], eq[i]);
            chk(got_l[i] == (i == eq.size() - 1), "R9", $sformatf("tlast at %0d", i),
                got_l[i], (i == eq.size() - 1));
            // R3: stuffed zero in the very next cycle
            if (i + 1 < n && i + 1 < eq.size() && eq[i] == 8'hFF && eq[i+1] == 8'h00)
                chk(got_c[i+1] == got_c[i] + 1, "R3", "stuff cycle gap",
                    got_c[i+1] - got_c[i], 1);
        end
        chk(frame_bytes == 24'(eq.size()), "R10", "frame_bytes", frame_bytes, eq.size());
        got_d.delete(); got_l.delete(); got_c.delete(); eq.delete(); mq.delete();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R1", "tvalid after reset", m_tvalid, 0);
        chk(m_tlast == 1'b0, "R1", "tlast after reset", m_tlast, 0);
        chk(frame_bytes == '0, "R1", "frame_bytes after reset", frame_bytes, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    endtask

    task automatic t_basic();
        restart_mcus = 16'd0;
        op_code(27'b101, 3);
        op_code(27'h1F, 5);
        for (int l = 1; l <= 27; l++)
            op_code(27'((32'h9E37_79B9 * l) >> 3), l);
        op_flush();
        op_code(27'h2A, 6);
        op_eoi_check("R2 R4");
    endtask

    task automatic t_stuff();
        restart_mcus = 16'd0;
        op_code(27'hFF, 8);
        op_code(27'hFF, 8);
        op_code(27'h12, 8);
        op_code(27'hF, 4);
        op_flush();
        op_code(27'h7F, 7);
        op_eoi_check("R3 R4");
    endtask

    task automatic t_backpressure();
        restart_mcus = 16'd0;
        stalls = 0;
        for (int i = 0; i < 24; i++)
            op_code((i % 3 == 0) ? 27'h7FF_FFFF : 27'(32'h0A5_C3E1 + i), 27);
        chk(stalls > 0, "R5", "ready dropped under load", stalls, 1);
        op_eoi_check("R5");
    endtask

    task automatic t_restart_wrap();
        restart_mcus = 16'd2;
        for (int m = 0; m < 19; m++) begin
            op_code(27'((m * 5 + 3) & 27'h3F), 6);
            op_code(27'h3, 2);
            op_mcu();
        end
        op_code(27'h15, 5);
        op_mcu();
        // interval reached here: armed restart must be dropped by end of image
        op_eoi_check("R6 R7 R8 R9");
    endtask

    task automatic t_restart_new_frame();
        restart_mcus = 16'd3;
        for (int m = 0; m < 4; m++) begin
            op_code(27'hFF, 8);
            op_mcu();
        end
        op_code(27'h1, 1);
        op_eoi_check("R7 R6");
    endtask

    task automatic t_no_restart();
        restart_mcus = 16'd0;
        for (int m = 0; m < 6; m++) begin
            op_code(27'h5, 3);
            op_mcu();
        end
        op_code(27'h0, 4);
        op_eoi_check("R6");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_stuff();
        t_backpressure();
        t_restart_wrap();
        t_restart_new_frame();
        t_no_restart();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule